// File: doc/BRIEF.md
# Double-LSB Significand Alignment and Rounding Unit

This unit prepares double-LSB two's-complement significands for floating-point arithmetic. An input word holds an 8-bit integer core plus one extra least-significant bit, which has the same weight as core bit 0. The unit first widens the word with 4 fractional bits. It then shifts the widened word left or right by a given amount, with fill rules that keep the value exact in double-LSB terms.

The unit then rounds the shifted word back to 8 integer bits using round-to-nearest-even. The integer core is passed through untouched, and only the extra bit of the result is chosen, so no carry propagates. Both the shifted wide word and the rounded narrow word are registered once. They appear on the clock edge after the inputs are applied.

Top module: `dlsb_align_round`

## Requirements
- R1: Precision extension places the input core in the top 8 bits of a 12-bit word and copies the input extra bit into all 4 new fractional bits and into the new extra bit. With a right shift of 0, `wide_o` equals `{sig_i[8:1], {4{sig_i[0]}}, sig_i[0]}`.
- R2: A right shift (`left_i`=0) by h is arithmetic on the 12-bit word `wide_o[12:1]`, with bit 11 of the extended word copied into the vacated top positions.
- R3: After a right shift, the extra bit `wide_o[0]` equals the AND of the input extra bit and every bit shifted off the low end.
- R4: A right shift with h of 12 or more sets the 12-bit word to copies of the sign bit. The extra bit becomes the AND of the input extra bit and all 12 extended bits.
- R5: A left shift (`left_i`=1) by h shifts copies of the extra bit into the low end and keeps the extra bit. With h of 12 or more, all 13 bits of `wide_o` equal the input extra bit.
- R6: The rounded output never alters the integer core: `narrow_o[8:1]` always equals `wide_o[12:5]`.
- R7: With rounding enabled, the fraction is classified from bits `wide_o[4:0]`. Bit 4 is the round bit. The sticky-OR and sticky-AND bits are formed over bits 3..0, where bit 0 is the extra bit. The fraction is below one half when the round bit is 0 and sticky-AND is 0, and `narrow_o[0]` is then 0. It is above one half when the round bit is 1 and sticky-OR is 1, and `narrow_o[0]` is then 1.
- R8: In every other case the fraction is exactly one half, and `narrow_o[0]` equals integer bit 0 (`wide_o[5]`).
- R9: With `rnd_en_i` low, the fraction is chopped and `narrow_o[0]` is 0.
- R10: Outputs change one clock edge after the inputs. While `rst_n` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_i | input | 9 | Significand: core in bits 8..1, extra bit in bit 0 |
| shamt_i | input | 4 | Shift amount h |
| left_i | input | 1 | 1 = left shift, 0 = right shift |
| rnd_en_i | input | 1 | 1 = round to nearest even, 0 = chop |
| wide_o | output | 13 | Shifted extended word (bits 12..1) and its extra bit (bit 0) |
| narrow_o | output | 9 | Rounded core (bits 8..1) and chosen extra bit (bit 0) |

## Verification
Several properties are checked on every cycle:
- the rounded core matches the wide integer bits;
- a chopped result has a zero extra bit;
- strict below-half and above-half fractions pick the right extra bit;
- saturated shifts produce uniform words;
- an unshifted extension replicates the extra bit.

Other behaviours can only be shown through the bench's chosen inputs, because they depend on values that are shifted away:
- the sticky-AND on shifted-out bits;
- the sign fill of negative words;
- tie-breaking on the integer bit, including ties created purely by the extra bit.

// File: rtl/dlsb_align_round.sv
module dlsb_align_round #(
  parameter int K   = 8,
  parameter int L   = 4,
  parameter int SHW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [K:0]       sig_i,
  input  logic [SHW-1:0]   shamt_i,
  input  logic             left_i,
  input  logic             rnd_en_i,
  output logic [K+L:0]     wide_o,
  output logic [K:0]       narrow_o
);
  localparam int N = K + L;

  logic           xb;
  logic [N-1:0]   ext;
  logic [N-1:0]   lowmask;
  logic [N-1:0]   sh_r, sh_l, sh;
  logic           xb_r, xb_n;
  logic           rbit, s_or, s_and, below, above, up;

  assign xb  = sig_i[0];
  assign ext = {sig_i[K:1], {L{xb}}};

  always_comb begin
    if (int'(shamt_i) >= N) lowmask = '1;
    else                    lowmask = ({{(N-1){1'b0}}, 1'b1} << shamt_i) - 1'b1;
  end

  assign sh_r = $signed(ext) >>> shamt_i;
  assign xb_r = xb & (&(ext | ~lowmask));
  assign sh_l = (ext << shamt_i) | (xb ? lowmask : '0);

  assign sh   = left_i ? sh_l : sh_r;
  assign xb_n = left_i ? xb   : xb_r;

  assign rbit  = sh[L-1];
  assign s_or  = |{sh[L-2:0], xb_n};
  assign s_and = &{sh[L-2:0], xb_n};
  assign below = ~rbit & ~s_and;
  assign above = rbit & s_or;
  assign up    = rnd_en_i & (above | (~below & ~above & sh[L]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wide_o   <= '0;
      narrow_o <= '0;
    end else begin
      wide_o   <= {sh, xb_n};
      narrow_o <= {sh[N-1:L], up};
    end
  end

  // R6
  core_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_o[K:1] == wide_o[N:L+1]);

  // R9
  chop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rnd_en_i |=> narrow_o[0] == 1'b0);

  // R7
  above_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_en_i && rst_n) |=> (wide_o[L] && (|wide_o[L-1:0])) -> narrow_o[0]);

  // R7
  below_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_en_i |=> (!wide_o[L] && !(&wide_o[L-1:0])) -> !narrow_o[0]);

  // R4
  rsat_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!left_i && int'(shamt_i) >= N) |=>
      (wide_o[N:1] == '0 || wide_o[N:1] == '1));

  // R5
  lsat_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (left_i && int'(shamt_i) >= N) |=>
      (wide_o == '0 || wide_o == '1) && wide_o[0] == $past(sig_i[0]));

  // R1
  extend_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!left_i && shamt_i == '0) |=>
      wide_o[L:0] == {(L+1){$past(sig_i[0])}} && wide_o[N:L+1] == $past(sig_i[K:1]));
endmodule

// File: tb/sim_dlsb_align_round.sv
module sim_dlsb_align_round;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  sig_i = '0;
  logic [3:0]  shamt_i = '0;
  logic        left_i = 1'b0;
  logic        rnd_en_i = 1'b0;
  logic [12:0] wide_o;
  logic [8:0]  narrow_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dlsb_align_round u0 (
    .clk(clk), .rst_n(rst_n), .sig_i(sig_i), .shamt_i(shamt_i),
    .left_i(left_i), .rnd_en_i(rnd_en_i), .wide_o(wide_o), .narrow_o(narrow_o)
  );

  // entry: sig[36:28] sh[27:24] left[23] en[22] wide[21:9] narrow[8:0]
  localparam int NV = 17;
  localparam logic [36:0] VEC [NV] = '{
    {9'h06B, 4'd0,  1'b0, 1'b1, 13'h06BF, 9'h06B},  // R1 R7 above
    {9'h06A, 4'd2,  1'b0, 1'b1, 13'h01A8, 9'h01A},  // R2 R7 below
    {9'h002, 4'd1,  1'b0, 1'b1, 13'h0010, 9'h000},  // R8 tie even down
    {9'h006, 4'd1,  1'b0, 1'b1, 13'h0030, 9'h003},  // R8 tie odd up
    {9'h01D, 4'd1,  1'b0, 1'b1, 13'h00EF, 9'h00F},  // R8 R3 tie via extra bit, up
    {9'h019, 4'd1,  1'b0, 1'b1, 13'h00CF, 9'h00C},  // R8 tie via extra bit, down
    {9'h120, 4'd4,  1'b0, 1'b1, 13'h1F20, 9'h1F2},  // R2 negative sign fill
    {9'h00E, 4'd2,  1'b0, 1'b1, 13'h0038, 9'h003},  // R3 zero extra bit
    {9'h009, 4'd5,  1'b0, 1'b1, 13'h0004, 9'h000},  // R3 zero among shifted-out
    {9'h1FF, 4'd15, 1'b0, 1'b1, 13'h1FFF, 9'h1FF},  // R4 all ones
    {9'h1FD, 4'd12, 1'b0, 1'b1, 13'h1FFE, 9'h1FF},  // R4 one zero discarded
    {9'h0FF, 4'd13, 1'b0, 1'b1, 13'h0000, 9'h000},  // R4 positive
    {9'h00B, 4'd2,  1'b1, 1'b1, 13'h02FF, 9'h02F},  // R5 ones shifted in
    {9'h00A, 4'd3,  1'b1, 1'b1, 13'h0500, 9'h050},  // R5 zeros shifted in
    {9'h025, 4'd14, 1'b1, 1'b1, 13'h1FFF, 9'h1FF},  // R5 saturate ones
    {9'h024, 4'd12, 1'b1, 1'b1, 13'h0000, 9'h000},  // R5 saturate zeros
    {9'h06B, 4'd0,  1'b0, 1'b0, 13'h06BF, 9'h06A}   // R9 chop
  };

  function automatic logic [12:0] ref_wide(input logic [8:0] s, input int h, input logic lft);
    logic [11:0] w, r;
    logic e, ea;
    e = s[0];
    for (int i = 0; i < 12; i++) w[i] = (i < 4) ? e : s[i-3];
    ea = e;
    for (int i = 0; i < 12; i++) begin
      if (lft) r[i] = (i - h >= 0) ? w[i-h] : e;
      else     r[i] = (i + h <= 11) ? w[i+h] : w[11];
    end
    if (!lft)
      for (int i = 0; i < 12; i++) if (i < h) ea = ea & w[i];
    return {r, ea};
  endfunction

  function automatic logic [8:0] ref_narrow(input logic [12:0] wd, input logic en);
    int sixteenths;
    logic u;
    sixteenths = int'(wd[4:1]) + int'(wd[0]);
    if (!en)                 u = 1'b0;
    else if (sixteenths < 8) u = 1'b0;
    else if (sixteenths > 8) u = 1'b1;
    else                     u = wd[5];
    return {wd[12:5], u};
  endfunction

  task automatic check(input string tag, input logic [12:0] ew, input logic [8:0] en_v);
    checks++;
    if (wide_o !== ew || narrow_o !== en_v) begin
      fails++;
      $display("FAIL %s: wide=%h narrow=%h expected wide=%h narrow=%h",
               tag, wide_o, narrow_o, ew, en_v);
    end
    checks++;
    if (narrow_o[8:1] !== wide_o[12:5]) begin
      fails++;
      $display("FAIL R6: core=%h expected %h", narrow_o[8:1], wide_o[12:5]);
    end
  endtask

  task automatic apply(input logic [8:0] s, input logic [3:0] h, input logic l, input logic en);
    @(negedge clk);
    sig_i = s; shamt_i = h; left_i = l; rnd_en_i = en;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    sig_i = 9'h1FF; shamt_i = 4'd3; left_i = 1'b1; rnd_en_i = 1'b1;
    @(negedge clk);
    checks++;
    if (wide_o !== '0 || narrow_o !== '0) begin
      fails++;
      $display("FAIL R10: reset wide=%h narrow=%h expected 0 0", wide_o, narrow_o);
    end
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][36:28], VEC[v][27:24], VEC[v][23], VEC[v][22]);
      check($sformatf("R1-set vector %0d", v), VEC[v][21:9], VEC[v][8:0]);
    end

    // R10 latency: output still holds old value right after an input change
    apply(9'h06B, 4'd0, 1'b0, 1'b1);
    @(posedge clk);
    #1 sig_i = 9'h000;
    checks++;
    if (wide_o !== 13'h06BF) begin
      fails++;
      $display("FAIL R10: wide=%h expected %h", wide_o, 13'h06BF);
    end
    @(negedge clk);

    for (int n = 0; n < 400; n++) begin
      logic [8:0] s; logic [3:0] h; logic l, en; logic [12:0] ew;
      s = 9'($urandom); h = 4'($urandom); l = 1'($urandom); en = ($urandom % 4) != 0;
      apply(s, h, l, en);
      ew = ref_wide(s, int'(h), l);
      check("R2 R3 R4 R5 R7 R8 R9 sweep", ew, ref_narrow(ew, en));
    end

    // R10 reset clears registered state
    rst_n = 1'b0;
    @(negedge clk);
    checks++;
    if (wide_o !== '0 || narrow_o !== '0) begin
      fails++;
      $display("FAIL R10: re-reset wide=%h narrow=%h expected 0 0", wide_o, narrow_o);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run incomplete expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule